// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits in the operand path of a simple processor's load/store pipeline. For each instruction it receives the addressing-mode code, two register values that the register file has already read, the sign-extended 16-bit displacement or immediate field, and an address-size bit. It then reports one of three things: where the memory operand lives, that the operand is the immediate itself, or that the operand is the register value. Modes that move their address register also produce a one-cycle write-back of the updated register value.

The memory-indirect mode needs one extra memory read. The unit issues a pointer read over a request/acknowledge handshake and holds `busy` high until the pointer returns. One cycle after the acknowledge it presents the fetched pointer as the effective address. Every address the unit produces is masked to the selected address size: either 24 bits or 31 bits, with the upper bits forced to zero.

Top module: `eagu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `busy`, `mem_req` and `wb_en` are all 0.
- R2: Mode 3'b000 (register): one cycle after an accepted `in_valid`, `out_valid` is 1, `out_opnd` equals `base_val`, and `out_mem`, `out_imm` and `out_ea` are all 0.
- R3: Mode 3'b001 (immediate): `out_imm` is 1, `out_opnd` equals `disp` sign-extended to 32 bits, `out_mem` is 0 and `out_ea` is 0. `out_imm` and `out_mem` are never 1 at the same time.
- R4: Mode 3'b010 (absolute): `out_mem` is 1 and `out_ea` is the sign-extended `disp`, masked to the address size.
- R5: Mode 3'b011 (register indirect): `out_mem` is 1 and `out_ea` is the masked `base_val`.
- R6: Mode 3'b100 (pre-decrement): `out_ea` is mask(`base_val` − step). In the same cycle `wb_en` is 1, `wb_idx` equals `base_idx` and `wb_val` equals `out_ea`.
- R7: Mode 3'b101 (post-increment): `out_ea` is mask(`base_val`) and `wb_val` is mask(`base_val` + step), with `wb_en` high for that one output cycle. No mode other than 3'b100 and 3'b101 raises `wb_en`.
- R8: The step is 4 when `step_from_disp` is 0. It is the sign-extended `disp` when `step_from_disp` is 1.
- R9: Mode 3'b110 (indexed): `out_ea` is mask(`base_val` + `index_val` + sign-extended `disp`), with carries out of bit 31 dropped.
- R10: Mode 3'b111 (memory indirect): one cycle after acceptance, `mem_req` and `busy` are 1 and `mem_addr` is mask(`base_val` + sign-extended `disp`). Both stay unchanged until `mem_ack` is sampled high. On the next cycle `busy` is 0, `out_valid` is 1 and `out_ea` is `mem_rdata` masked with the address size that was captured at issue.
- R11: Masking: when `wide` is 0, bits 31..24 of every address and write-back value are 0. When `wide` is 1, only bit 31 is forced to 0.
- R12: An `in_valid` that arrives while `busy` is 1 is ignored: it produces no output, no write-back and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction operand request |
| mode | input | 3 | Addressing-mode code |
| wide | input | 1 | Address size: 0 = 24-bit, 1 = 31-bit |
| step_from_disp | input | 1 | Take the modify step from `disp` instead of the fixed step |
| base_idx | input | 3 | Index of the base/address register |
| base_val | input | 32 | Contents of the base register |
| index_val | input | 32 | Contents of the index register |
| disp | input | 16 | Displacement / immediate field |
| busy | output | 1 | Indirect pointer fetch outstanding |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_rdata | input | 32 | Fetched pointer |
| out_valid | output | 1 | Result valid for one cycle |
| out_ea | output | 32 | Effective address |
| out_mem | output | 1 | Operand is in memory at `out_ea` |
| out_imm | output | 1 | Operand is the immediate |
| out_opnd | output | 32 | Operand value for register and immediate modes |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 3 | Register to write back |
| wb_val | output | 32 | Updated register value |

## Verification
On every cycle the assertions check the following: the top address bit is clear, an immediate result never claims a memory operand, and write-back only accompanies a memory result. While a pointer fetch is outstanding, the request and its address stay unchanged and no result appears. An acknowledge is always followed by a result with `busy` cleared. Only the bench's scenarios can show the actual arithmetic of each mode under both address sizes: the wrap of a pre-decrement below zero, step selection, indexed carries being dropped, and the use of the address size captured at issue rather than the live input.

// File: rtl/eagu.sv
module eagu #(
  parameter int DW     = 32,
  parameter int RW     = 3,
  parameter int DSW    = 16,
  parameter int STEP   = 4,
  parameter int NARROW = 24,
  parameter int WIDE   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    mode,
  input  logic          wide,
  input  logic          step_from_disp,
  input  logic [RW-1:0] base_idx,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] index_val,
  input  logic [DSW-1:0] disp,
  output logic          busy,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic [DW-1:0] out_ea,
  output logic          out_mem,
  output logic          out_imm,
  output logic [DW-1:0] out_opnd,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_val
);

  localparam logic [DW-1:0] MASK_N = {DW{1'b1}} >> (DW - NARROW);
  localparam logic [DW-1:0] MASK_W = {DW{1'b1}} >> (DW - WIDE);

  localparam logic [2:0] M_REG  = 3'b000;
  localparam logic [2:0] M_IMM  = 3'b001;
  localparam logic [2:0] M_ABS  = 3'b010;
  localparam logic [2:0] M_IND  = 3'b011;
  localparam logic [2:0] M_PRED = 3'b100;
  localparam logic [2:0] M_POST = 3'b101;
  localparam logic [2:0] M_IDX  = 3'b110;
  localparam logic [2:0] M_MIND = 3'b111;

  logic [DW-1:0] dext, step, msk, hold_msk;
  logic [DW-1:0] n_ea, n_opnd, n_wbv;
  logic          n_mem, n_imm, n_wb;
  logic          accept;

  assign dext   = {{(DW-DSW){disp[DSW-1]}}, disp};
  assign step   = step_from_disp ? dext : DW'(STEP);
  assign msk    = wide ? MASK_W : MASK_N;
  assign accept = in_valid && !mem_req;
  assign busy   = mem_req;

  always_comb begin
    n_ea   = '0;
    n_opnd = '0;
    n_wbv  = '0;
    n_mem  = 1'b1;
    n_imm  = 1'b0;
    n_wb   = 1'b0;
    case (mode)
      M_REG:  begin n_mem = 1'b0; n_opnd = base_val; end
      M_IMM:  begin n_mem = 1'b0; n_imm = 1'b1; n_opnd = dext; end
      M_ABS:  n_ea = dext & msk;
      M_IND:  n_ea = base_val & msk;
      M_PRED: begin
        n_ea  = (base_val - step) & msk;
        n_wb  = 1'b1;
        n_wbv = n_ea;
      end
      M_POST: begin
        n_ea  = base_val & msk;
        n_wb  = 1'b1;
        n_wbv = (base_val + step) & msk;
      end
      M_IDX:  n_ea = (base_val + index_val + dext) & msk;
      default: n_ea = (base_val + dext) & msk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ea    <= '0;
      out_mem   <= 1'b0;
      out_imm   <= 1'b0;
      out_opnd  <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_val    <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      hold_msk  <= '0;
    end else begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      if (accept && mode != M_MIND) begin
        out_valid <= 1'b1;
        out_ea    <= n_ea;
        out_mem   <= n_mem;
        out_imm   <= n_imm;
        out_opnd  <= n_opnd;
        wb_en     <= n_wb;
        wb_idx    <= base_idx;
        wb_val    <= n_wbv;
      end
      if (accept && mode == M_MIND) begin
        mem_req  <= 1'b1;
        mem_addr <= n_ea;
        hold_msk <= msk;
      end
      if (mem_req && mem_ack) begin
        mem_req   <= 1'b0;
        out_valid <= 1'b1;
        out_ea    <= mem_rdata & hold_msk;
        out_mem   <= 1'b1;
        out_imm   <= 1'b0;
        out_opnd  <= '0;
      end
    end
  end

endmodule

// File: rtl/eagu_chk.sv
module eagu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        out_valid,
  input logic [31:0] out_ea,
  input logic        out_mem,
  input logic        out_imm,
  input logic        wb_en,
  input logic [31:0] wb_val
);

  // R11
  ea_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_ea[31]);

  // R11
  wb_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !wb_val[31]);

  // R3
  imm_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_imm |-> !out_mem);

  // R6
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_valid && out_mem));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (out_valid && !busy));

  // R12
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!out_valid && !wb_en));

endmodule

bind eagu eagu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .out_valid(out_valid), .out_ea(out_ea), .out_mem(out_mem),
  .out_imm(out_imm), .wb_en(wb_en), .wb_val(wb_val)
);

// File: tb/sim_eagu.sv
`timescale 1ns/1ps
module sim_eagu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic        wide = 1'b0;
  logic        step_from_disp = 1'b0;
  logic [2:0]  base_idx = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [15:0] disp = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, mem_req, out_valid, out_mem, out_imm, wb_en;
  logic [31:0] mem_addr, out_ea, out_opnd, wb_val;
  logic [2:0]  wb_idx;

  always #2 clk = ~clk;

  eagu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .wide(wide),
    .step_from_disp(step_from_disp), .base_idx(base_idx), .base_val(base_val),
    .index_val(index_val), .disp(disp), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ea(out_ea), .out_mem(out_mem), .out_imm(out_imm),
    .out_opnd(out_opnd), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic        mem;
    logic        imm;
    logic [31:0] opnd;
    logic        wb;
    logic [2:0]  wbi;
    logic [31:0] wbv;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] mk(input logic w);
    return w ? 32'h7FFF_FFFF : 32'h00FF_FFFF;
  endfunction

  function automatic exp_t model(input logic [2:0] m, input logic w, input logic ss,
      input logic [2:0] bi, input logic [31:0] b, input logic [31:0] x,
      input logic [15:0] d, input logic [31:0] rd);
    exp_t e;
    logic [31:0] st;
    e = '0;
    st = ss ? sx(d) : 32'd4;
    e.mem = 1'b1;
    e.wbi = bi;
    case (m)
      3'd0: begin e.mem = 1'b0; e.opnd = b; e.wbi = '0; end
      3'd1: begin e.mem = 1'b0; e.imm = 1'b1; e.opnd = sx(d); e.wbi = '0; end
      3'd2: e.ea = sx(d) & mk(w);
      3'd3: e.ea = b & mk(w);
      3'd4: begin e.ea = (b - st) & mk(w); e.wb = 1'b1; e.wbv = e.ea; end
      3'd5: begin e.ea = b & mk(w); e.wb = 1'b1; e.wbv = (b + st) & mk(w); end
      3'd6: e.ea = (b + x + sx(d)) & mk(w);
      default: e.ea = rd & mk(w);
    endcase
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected result actual=%h expected=none", out_ea);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (out_ea !== e.ea || out_mem !== e.mem || out_imm !== e.imm ||
            out_opnd !== e.opnd || wb_en !== e.wb ||
            (e.wb && (wb_val !== e.wbv || wb_idx !== e.wbi))) begin
          fails++;
          $display("FAIL %s actual ea=%h mem=%b imm=%b opnd=%h wb=%b/%0d/%h expected ea=%h mem=%b imm=%b opnd=%h wb=%b/%0d/%h",
                   t, out_ea, out_mem, out_imm, out_opnd, wb_en, wb_idx, wb_val,
                   e.ea, e.mem, e.imm, e.opnd, e.wb, e.wbi, e.wbv);
        end
      end
    end
  end

  task automatic issue(input string tag, input logic [2:0] m, input logic w, input logic ss,
      input logic [2:0] bi, input logic [31:0] b, input logic [31:0] x, input logic [15:0] d);
    expq.push_back(model(m, w, ss, bi, b, x, d, '0));
    tagq.push_back(tag);
    mode = m; wide = w; step_from_disp = ss; base_idx = bi;
    base_val = b; index_val = x; disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic indirect(input logic w, input logic [31:0] b, input logic [15:0] d,
      input logic [31:0] ptr, input int wait_cyc);
    expq.push_back(model(3'd7, w, 1'b0, 3'd0, b, '0, d, ptr));
    tagq.push_back("R10");
    mode = 3'd7; wide = w; base_idx = 3'd2; base_val = b; disp = d; in_valid = 1'b1;
    @(negedge clk);
    // R10: request raised with masked pointer address
    chk("R10 req", {31'd0, mem_req & busy}, 32'd1);
    chk("R10 addr", mem_addr, (b + sx(d)) & mk(w));
    // R12: a new request while busy must be ignored; wide flips to prove capture
    mode = 3'd5; base_val = 32'h0000_0100; wide = ~w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < wait_cyc; i++) @(negedge clk);
    chk("R10 hold", {31'd0, busy}, 32'd1);
    chk("R12 no wb", {31'd0, wb_en}, 32'd0);
    mem_ack = 1'b1; mem_rdata = ptr;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = '0;
    chk("R10 done", {31'd0, busy}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset", {28'd0, out_valid, busy, mem_req, wb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", {28'd0, out_valid, busy, mem_req, wb_en}, 32'd0);

    for (int w = 0; w < 2; w++) begin
      issue("R2", 3'd0, w[0], 1'b0, 3'd1, 32'hDEAD_BEEF, '0, 16'h1234);
      issue("R3", 3'd1, w[0], 1'b0, 3'd1, 32'h1111_1111, '0, 16'h8001);
      issue("R4", 3'd2, w[0], 1'b0, 3'd0, '0, '0, 16'hFFF0);
      issue("R5", 3'd3, w[0], 1'b0, 3'd3, 32'hF123_4567, '0, '0);
      issue("R6", 3'd4, w[0], 1'b0, 3'd4, 32'h0000_0002, '0, '0);
      issue("R6", 3'd4, w[0], 1'b0, 3'd5, 32'h8000_1000, '0, '0);
      issue("R7", 3'd5, w[0], 1'b0, 3'd6, 32'h7FFF_FFFE, '0, '0);
      issue("R8", 3'd5, w[0], 1'b1, 3'd7, 32'h0040_0000, '0, 16'h0100);
      issue("R8", 3'd4, w[0], 1'b1, 3'd2, 32'h0040_0000, '0, 16'hFFF8);
      issue("R9", 3'd6, w[0], 1'b0, 3'd0, 32'hFFFF_FF00, 32'h0000_0200, 16'hFFFC);
      issue("R11", 3'd6, w[0], 1'b0, 3'd0, 32'h7F00_0000, 32'h00FF_FFFF, 16'h0002);
      indirect(w[0], 32'h0100_0000 + w, 16'hFFFE, 32'hABCD_EF01, 2 + w);
    end
    // back-to-back issues without gap
    expq.push_back(model(3'd3, 1'b1, 1'b0, 3'd1, 32'h0000_0010, '0, '0, '0)); tagq.push_back("R5");
    expq.push_back(model(3'd5, 1'b0, 1'b0, 3'd1, 32'h0000_0020, '0, '0, '0)); tagq.push_back("R7");
    mode = 3'd3; wide = 1'b1; step_from_disp = 1'b0; base_idx = 3'd1; base_val = 32'h10; in_valid = 1'b1;
    @(negedge clk);
    mode = 3'd5; wide = 1'b0; base_val = 32'h20;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 queue empty", expq.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule